// File: doc/BRIEF.md
# Postfix Stack Calculator Core

This block evaluates arithmetic written in postfix order. A program of 9-bit words sits in a small memory with two ports. A program counter reads words in sequence through a read-only port. A stack pointer reads and writes operands through the other port. Two registers hold the topmost operands. Register `B` is the newest value and register `A` is the one below it. Deeper operands spill into the same memory, into slots whose program words have already been consumed.

A control state machine counts the available operands: none, one, exactly two, or more than two. From that count it decides, for each word, whether an operand really moves to or from memory. Fetch of the next word overlaps with execution of the current one. The machine stops for good on an end-of-file word, or on a malformed program.

The program is written through a load port while reset is held. After reset is released, the result is read from `result` once `halted` or `error` goes high.

Top module: `stack_calc`

## Requirements
- R1: A word with bit 8 clear is a data operand. Bits 7:0 hold a two's-complement value in the range -127..+127, and it becomes the new top of stack. A word with bit 8 set is an operation code in bits 7:0.
- R2: Code 0x00 (word 0x100) subtracts. The lower operand minus the top operand replaces both, wrapped to 8 bits. For example, 8, 6, - gives 2.
- R3: Code 0x01 (word 0x101) adds the two topmost operands, and the sum replaces both, wrapped to 8 bits.
- R4: Word 0x1FF stops execution. `halted` is set, `error` stays low, and `result` shows the top operand. With no operand, `result` is 0.
- R5: An add or subtract that executes while fewer than two operands are available sets `error`, and `halted` stays low.
- R6: Any other operation code, and the data word 0x080 (value -128, outside the range), set `error`.
- R7: Operands beyond the top two go to memory in push/pop order and come back correctly. So 3, 5, 8, 6, -, +, + gives 10, and 1, 2, 3, 4, 5, +, +, +, + gives 15.
- R8: While `rst` is high, `result` is 0 and `halted` and `error` are low. A write on the load port stores `ld_data` at `ld_addr`, and the program starts from address 0 once reset is released.
- R9: Once `halted` or `error` is set, it stays set and `result` no longer changes until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Program load write enable |
| ld_addr | input | 4 | Program load address |
| ld_data | input | 9 | Program load word |
| result | output | 8 | Top operand (register B) |
| halted | output | 1 | End-of-file reached |
| error | output | 1 | Malformed program detected |

## Verification
The hardest state to reach from the ports is a pop that empties the memory part of the stack. In that case the machine must leave the "more than two" state for "exactly two", because the stack pointer has returned to its base. Programs of the form a, b, c, -, - force one spill and one refill. A five-deep chain of adds forces several spills and a refill on every operator. A coarse sweep over all three operands compares the results with arithmetic computed in the bench.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;
   localparam logic [7:0] OPC_SUB = 8'h00;
   localparam logic [7:0] OPC_ADD = 8'h01;
   localparam logic [7:0] OPC_EOF = 8'hFF;

   typedef enum logic [2:0] {
      ST_EMPTY = 3'd0,
      ST_ONE   = 3'd1,
      ST_TWO   = 3'd2,
      ST_DEEP  = 3'd3,
      ST_ERR   = 3'd4,
      ST_HALT  = 3'd5
   } calc_state_t;

   typedef struct packed {
      logic fetch_en;
      logic op_path;
      logic a_load;
      logic b_load;
      logic sp_up;
      logic sp_step;
      logic halt_n;
      logic err_n;
   } calc_ctl_t;
endpackage

// File: rtl/stack_calc_mem.sv
module stack_calc_mem #(
   parameter int AW = 4,
   parameter int WW = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] p_addr,
   input  logic [WW-1:0] p_wdata,
   output logic [WW-1:0] p_rdata,
   input  logic [AW-1:0] q_addr,
   output logic [WW-1:0] q_rdata
);
   localparam int DEPTH = 1 << AW;

   logic [WW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[p_addr] <= p_wdata;
   end

   assign p_rdata = store[p_addr];
   assign q_rdata = store[q_addr];
endmodule

// File: rtl/stack_calc_alu.sv
module stack_calc_alu #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   input  logic          sub,
   output logic [DW-1:0] res
);
   assign res = sub ? (lhs - rhs) : (lhs + rhs);
endmodule

// File: rtl/stack_calc_ctrl.sv
module stack_calc_ctrl
   import stack_calc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        word_valid,
   input  logic [DW:0] word,
   input  logic        sp_at_one,
   output calc_state_t state,
   output calc_ctl_t   ctl
);
   localparam logic [DW-1:0] BAD_DATA = {1'b1, {(DW-1){1'b0}}};

   calc_state_t nxt;
   logic is_op, is_data, is_arith, is_eof;

   always_comb begin
      is_op    = word[DW];
      is_eof   = is_op && (word[DW-1:0] == DW'(OPC_EOF));
      is_arith = is_op && ((word[DW-1:0] == DW'(OPC_SUB)) || (word[DW-1:0] == DW'(OPC_ADD)));
      is_data  = !is_op && (word[DW-1:0] != BAD_DATA);
   end

   always_comb begin
      nxt = state;
      ctl = '{fetch_en: 1'b0, op_path: 1'b0, a_load: 1'b0, b_load: 1'b0,
              sp_up: 1'b0, sp_step: 1'b0, halt_n: 1'b1, err_n: 1'b1};
      if (state == ST_HALT) begin
         ctl.halt_n = 1'b0;
      end else if (state == ST_ERR) begin
         ctl.err_n = 1'b0;
      end else begin
         ctl.fetch_en = 1'b1;
         if (word_valid) begin
            if (is_eof) begin
               nxt = ST_HALT;
            end else if (is_data) begin
               ctl.b_load = 1'b1;
               unique case (state)
                  ST_EMPTY: nxt = ST_ONE;
                  ST_ONE: begin
                     ctl.a_load = 1'b1;
                     nxt = ST_TWO;
                  end
                  default: begin
                     ctl.a_load  = 1'b1;
                     ctl.sp_up   = 1'b1;
                     ctl.sp_step = 1'b1;
                     nxt = ST_DEEP;
                  end
               endcase
            end else if (is_arith && (state == ST_TWO || state == ST_DEEP)) begin
               ctl.op_path = 1'b1;
               ctl.b_load  = 1'b1;
               if (state == ST_TWO) begin
                  nxt = ST_ONE;
               end else begin
                  ctl.a_load  = 1'b1;
                  ctl.sp_step = 1'b1;
                  nxt = sp_at_one ? ST_TWO : ST_DEEP;
               end
            end else begin
               nxt = ST_ERR;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_EMPTY;
      else     state <= nxt;
   end
endmodule

// File: rtl/stack_calc.sv
module stack_calc
   import stack_calc_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW:0]   ld_data,
   output logic [DW-1:0] result,
   output logic          halted,
   output logic          error
);
   localparam int WW = DW + 1;

   if (DW < 2) begin : g_bad_dw
      $error("stack_calc: DW must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("stack_calc: AW must be at least 2");
   end

   calc_state_t   state;
   calc_ctl_t     ctl;
   logic [AW-1:0] pc_q, sp_q, stk_addr, mem_addr;
   logic [WW-1:0] ir_q, prog_word, stk_word, mem_wdata;
   logic          ir_vld_q, mem_we;
   logic [DW-1:0] a_q, b_q, alu_res;

   stack_calc_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst(rst), .word_valid(ir_vld_q), .word(ir_q),
      .sp_at_one(sp_q == AW'(1)), .state(state), .ctl(ctl)
   );

   stack_calc_alu #(.DW(DW)) u_alu (
      .lhs(a_q), .rhs(b_q), .sub(ir_q[DW-1:0] == DW'(OPC_SUB)), .res(alu_res)
   );

   always_comb begin
      stk_addr  = (ctl.sp_step && !ctl.sp_up) ? (sp_q - AW'(1)) : sp_q;
      mem_addr  = ld_en ? ld_addr : stk_addr;
      mem_wdata = ld_en ? ld_data : {1'b0, a_q};
      mem_we    = ld_en || (!rst && ctl.sp_step && ctl.sp_up);
   end

   stack_calc_mem #(.AW(AW), .WW(WW)) u_mem (
      .clk(clk), .we(mem_we), .p_addr(mem_addr), .p_wdata(mem_wdata),
      .p_rdata(stk_word), .q_addr(pc_q), .q_rdata(prog_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         sp_q     <= '0;
         ir_q     <= '0;
         ir_vld_q <= 1'b0;
         a_q      <= '0;
         b_q      <= '0;
      end else begin
         if (ctl.fetch_en) begin
            ir_q     <= prog_word;
            ir_vld_q <= 1'b1;
            pc_q     <= pc_q + AW'(1);
         end
         if (ctl.sp_step) sp_q <= ctl.sp_up ? (sp_q + AW'(1)) : (sp_q - AW'(1));
         if (ctl.a_load)  a_q  <= ctl.op_path ? stk_word[DW-1:0] : b_q;
         if (ctl.b_load)  b_q  <= ctl.op_path ? alu_res : ir_q[DW-1:0];
      end
   end

   assign result = b_q;
   assign halted = !ctl.halt_n;
   assign error  = !ctl.err_n;
endmodule

// File: rtl/stack_calc_chk.sv
module stack_calc_chk #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst,
   input logic [DW-1:0] result,
   input logic          halted,
   input logic          error,
   input logic [AW-1:0] pc,
   input logic [AW-1:0] sp
);
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (result == '0 && !halted && !error));

   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   p_error_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      error |=> error);

   p_frozen_result_r9: assert property (@(posedge clk) disable iff (rst)
      (halted || error) |=> ($stable(result) && $stable(pc) && $stable(sp)));

   p_halt_no_error_r4: assert property (@(posedge clk) disable iff (rst)
      !(halted && error));

   p_sp_single_step_r7: assert property (@(posedge clk) disable iff (rst)
      (sp == $past(sp)) || (sp == $past(sp) + AW'(1)) || (sp == $past(sp) - AW'(1)));
endmodule

bind stack_calc stack_calc_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst(rst), .result(result), .halted(halted), .error(error),
   .pc(pc_q), .sp(sp_q)
);

// File: tb/tb_stack_calc.sv
module tb_stack_calc;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ld_en = 1'b0;
   logic [3:0] ld_addr = '0;
   logic [8:0] ld_data = '0;
   logic [7:0] result;
   logic       halted, error;

   int checks = 0;
   int fails = 0;
   logic [8:0] prog [16];

   localparam logic [8:0] W_SUB = 9'h100;
   localparam logic [8:0] W_ADD = 9'h101;
   localparam logic [8:0] W_EOF = 9'h1FF;

   always #10 clk = ~clk;

   stack_calc dut (.clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
                   .ld_data(ld_data), .result(result), .halted(halted), .error(error));

   function automatic logic [8:0] dat(input int v);
      logic [7:0] b = 8'(v);
      return {1'b0, b};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 16; i++) prog[i] = W_EOF;
   endtask

   task automatic run(input string req, input int exp_res, input bit exp_halt, input bit exp_err);
      rst = 1'b1;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = 4'(i); ld_data = prog[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
      @(negedge clk);
      check("R8 reset outputs", {result, halted, error}, 0);
      rst = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (halted || error) break;
      end
      check({req, " result"}, int'(result), exp_res & 255);
      check({req, " flags"}, {halted, error}, {exp_halt, exp_err});
   endtask

   initial begin
      #3_800_000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R7: the worked example, 3 5 8 6 - + + = 10
      clear_prog();
      prog[0] = dat(3); prog[1] = dat(5); prog[2] = dat(8); prog[3] = dat(6);
      prog[4] = W_SUB; prog[5] = W_ADD; prog[6] = W_ADD;
      run("R7 example", 10, 1, 0);
      // R9: frozen after halt
      repeat (5) @(negedge clk);
      check("R9 result hold", int'(result), 10);
      check("R9 halt hold", {halted, error}, 2);

      // R7: deep chain, 1 2 3 4 5 + + + + = 15
      clear_prog();
      for (int i = 0; i < 5; i++) prog[i] = dat(i + 1);
      for (int i = 5; i < 9; i++) prog[i] = W_ADD;
      run("R7 deep chain", 15, 1, 0);

      // R4: EOF with no, one and two operands
      clear_prog();
      run("R4 eof empty", 0, 1, 0);
      clear_prog(); prog[0] = dat(-5);
      run("R4 eof one", -5, 1, 0);
      clear_prog(); prog[0] = dat(7); prog[1] = dat(9);
      run("R4 eof two", 9, 1, 0);

      // R5: operator short of operands
      clear_prog(); prog[0] = W_ADD;
      run("R5 op on empty", 0, 0, 1);
      clear_prog(); prog[0] = dat(4); prog[1] = W_SUB;
      run("R5 op on one", 4, 0, 1);
      repeat (5) @(negedge clk);
      check("R9 error hold", {halted, error, result}, {2'b01, 8'd4});

      // R6: unknown opcode and out-of-range data
      clear_prog(); prog[0] = dat(1); prog[1] = dat(2); prog[2] = 9'h105;
      run("R6 bad opcode", 2, 0, 1);
      clear_prog(); prog[0] = 9'h080;
      run("R6 bad data", 0, 0, 1);

      // R1 R2 R3: two-operand sweep
      for (int a = -127; a <= 127; a += 9) begin
         for (int b = -127; b <= 127; b += 9) begin
            clear_prog(); prog[0] = dat(a); prog[1] = dat(b); prog[2] = W_SUB;
            run("R2 sub sweep", a - b, 1, 0);
            prog[2] = W_ADD;
            run("R3 add sweep", a + b, 1, 0);
         end
      end

      // R7 R1: three-operand spill and refill, a b c - -
      for (int a = -127; a <= 127; a += 36) begin
         for (int b = -127; b <= 127; b += 36) begin
            for (int c = -127; c <= 127; c += 36) begin
               clear_prog();
               prog[0] = dat(a); prog[1] = dat(b); prog[2] = dat(c);
               prog[3] = W_SUB; prog[4] = W_SUB;
               run("R7 nested sweep", a - (b - c), 1, 0);
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule